// File: doc/BRIEF.md
# Power-Pulsed Cyclic Conversion Sequencer

This block sequences one channel of a cyclic analog-to-digital converter that is switched on only for the conversion itself. A start request arrives with a flag that says whether the channel saw a trigger. A triggered channel has its bias and current sources switched on. The block then waits one converter period so the analog bias can settle. After that it runs one two-phase converter cycle per resolved pair of bits. During each cycle a single shared amplifier is handed back and forth between the two capacitor networks. An untriggered channel finishes at once and is never powered.

All timing is derived from a fast system clock. One converter period is `CYCLE_TICKS` fast ticks and is split into two equal halves. The first half drives phase A and the second half drives phase B. Each phase opens only after a programmable dead time of at least one tick, so the two phase controls are never high together. At the last tick of every phase a one-tick digit strobe tells the downstream correction logic that a new raw digit pair is valid. All outputs come from registers, so they trail the internal state by one tick.

Top module: `pwr_pulse_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, all outputs (`pwr_en`, `ph_a`, `ph_b`, `digit_stb`, `busy`, `done`) are low.
- R2: A start sampled in idle with `ch_trig` high gives `pwr_en` and `busy` high one tick after the sampling edge.
- R3: No phase control is high during the recovery interval of `REC_TICKS` ticks after power-up. Phase A first opens `REC_TICKS + 1 + e` ticks after the sampling edge, where e is the effective dead time. A phase is never high while `pwr_en` is low.
- R4: A conversion contains exactly `RES_BITS/2` phase-A windows and `RES_BITS/2` phase-B windows. The windows strictly alternate, starting with phase A.
- R5: `ph_a` and `ph_b` are never high in the same tick. Each window lasts `CYCLE_TICKS/2 - e` ticks and is preceded by e low ticks.
- R6: `digit_stb` is a one-tick pulse on the last high tick of each phase window. There are `RES_BITS` strobes per conversion.
- R7: `done` is a one-tick pulse, `REC_TICKS + (RES_BITS/2)*CYCLE_TICKS + 1` ticks after the sampling edge. `busy` is low from then on.
- R8: `pwr_en` falls one tick after `done`.
- R9: A start with `ch_trig` low raises `done` for one tick, one tick after the sampling edge. `pwr_en`, `busy` and both phases stay low.
- R10: A start that arrives during a conversion is ignored. The conversion keeps its length and gives one `done` pulse.
- R11: The effective dead time e equals `dead_cfg`, except that 0 is taken as 1 and any value above `CYCLE_TICKS/2 - 1` is taken as `CYCLE_TICKS/2 - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Start-conversion request, sampled in idle |
| ch_trig | input | 1 | Channel registered a trigger; selects powered conversion |
| dead_cfg | input | DEAD_W | Requested dead time in ticks before each phase |
| pwr_en | output | 1 | Enable for the converter bias and current sources |
| ph_a | output | 1 | First-half phase control (network 1 samples, network 2 amplifies) |
| ph_b | output | 1 | Second-half phase control (roles swapped) |
| digit_stb | output | 1 | One-tick strobe at the end of each phase |
| busy | output | 1 | Powered conversion in progress |
| done | output | 1 | One-tick completion pulse |

## Verification
The embedded properties check, on every tick, the things that must hold at all times. The two phases are exclusive, and a phase never rises in the tick after the other one was high. A phase is only high while power is on. A strobe only falls inside an open phase and never lasts two ticks. `done` is a single pulse and power goes off right after it. A start that arrives mid-conversion never restarts the recovery. The directed scenarios cover what only a whole conversion shows. These are the exact tick at which power, the first phase and `done` appear, the count of windows and strobes, the strict alternation, the window width for several dead-time settings including both clamps, and the untriggered path.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_CONV = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int REC_TICKS  = 200,
  parameter int HALF_TICKS = 100,
  parameter int N_CYCLES   = 6,
  localparam int MAXT = (REC_TICKS > HALF_TICKS) ? REC_TICKS : HALF_TICKS,
  localparam int TW   = $clog2(MAXT),
  localparam int CW   = $clog2(N_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_en,
  input  logic          conv_en,
  output logic [TW-1:0] tick_q,
  output logic          half_q,
  output logic          warm_last,
  output logic          conv_last
);
  logic [TW-1:0] tick_d;
  logic          half_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          half_end;
  logic          cnt_ce;

  assign warm_last = warm_en && (tick_q == TW'(REC_TICKS - 1));
  assign half_end  = tick_q == TW'(HALF_TICKS - 1);
  assign conv_last = conv_en && half_end && half_q && (cyc_q == CW'(N_CYCLES - 1));
  assign cnt_ce    = warm_en || conv_en || (tick_q != '0) || half_q || (cyc_q != '0);

  always_comb begin
    tick_d = tick_q;
    half_d = half_q;
    cyc_d  = cyc_q;
    if (warm_en) begin
      tick_d = warm_last ? '0 : tick_q + 1'b1;
    end else if (conv_en) begin
      if (half_end) begin
        tick_d = '0;
        half_d = ~half_q;
        if (half_q) cyc_d = cyc_q + 1'b1;
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end else begin
      tick_d = '0;
      half_d = 1'b0;
      cyc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      half_q <= 1'b0;
      cyc_q  <= '0;
    end else if (cnt_ce) begin
      tick_q <= tick_d;
      half_q <= half_d;
      cyc_q  <= cyc_d;
    end
  end

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> (cyc_q < CW'(N_CYCLES))); // R4
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic ch_trig,
  input  logic warm_last,
  input  logic conv_last,
  output logic warm_en,
  output logic conv_en,
  output logic pwr_en_q,
  output logic busy_q,
  output logic done_q
);
  seq_state_t state_q, state_d;
  logic       powered_q, powered_d;
  logic       pwr_c, busy_c, done_c;

  always_comb begin
    state_d   = state_q;
    powered_d = powered_q;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        state_d   = ch_trig ? ST_WARM : ST_FIN;
        powered_d = ch_trig;
      end
      ST_WARM: if (warm_last) state_d = ST_CONV;
      ST_CONV: if (conv_last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign warm_en = state_q == ST_WARM;
  assign conv_en = state_q == ST_CONV;
  assign pwr_c   = warm_en || conv_en || ((state_q == ST_FIN) && powered_q);
  assign busy_c  = warm_en || conv_en;
  assign done_c  = state_q == ST_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      powered_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      powered_q <= powered_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      pwr_en_q <= pwr_c;
      busy_q   <= busy_c;
      done_q   <= done_c;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_PWR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !pwr_en_q); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && start_req) |=> (state_q != ST_WARM)); // R10
  AST_UNTRIG_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_req && !ch_trig) |=> ##1 !pwr_en_q); // R9
endmodule

// File: rtl/pps_phase.sv
module pps_phase #(
  parameter int HALF_TICKS = 100,
  parameter int TW         = 8,
  parameter int DEAD_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_en,
  input  logic [TW-1:0]     tick_q,
  input  logic              half_q,
  input  logic [DEAD_W-1:0] dead_cfg,
  output logic              ph_a_q,
  output logic              ph_b_q,
  output logic              stb_q
);
  localparam int DEAD_MAX = HALF_TICKS - 1;

  logic [31:0] eff_dead;
  logic        in_win;
  logic        ph_a_c, ph_b_c, stb_c;

  always_comb begin
    if (dead_cfg == '0)
      eff_dead = 32'd1;
    else if (32'(dead_cfg) > 32'(DEAD_MAX))
      eff_dead = 32'(DEAD_MAX);
    else
      eff_dead = 32'(dead_cfg);
  end

  assign in_win = 32'(tick_q) >= eff_dead;
  assign ph_a_c = conv_en && !half_q && in_win;
  assign ph_b_c = conv_en &&  half_q && in_win;
  assign stb_c  = conv_en && (tick_q == TW'(HALF_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a_q <= 1'b0;
      ph_b_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      ph_a_q <= ph_a_c;
      ph_b_q <= ph_b_c;
      stb_q  <= stb_c;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_a_q && ph_b_q)); // R5
  AST_GAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_b_q) |-> !$past(ph_a_q)); // R5
  AST_GAP_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_a_q) |-> !$past(ph_b_q)); // R5
  AST_STB_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (ph_a_q || ph_b_q)); // R6
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R6
endmodule

// File: rtl/pwr_pulse_seq.sv
module pwr_pulse_seq #(
  parameter int CYCLE_TICKS = 200,
  parameter int RES_BITS    = 12,
  parameter int REC_TICKS   = 200,
  parameter int DEAD_W      = 8,
  localparam int HALF_TICKS = CYCLE_TICKS / 2,
  localparam int N_CYCLES   = RES_BITS / 2,
  localparam int MAXT       = (REC_TICKS > HALF_TICKS) ? REC_TICKS : HALF_TICKS,
  localparam int TW         = $clog2(MAXT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              ch_trig,
  input  logic [DEAD_W-1:0] dead_cfg,
  output logic              pwr_en,
  output logic              ph_a,
  output logic              ph_b,
  output logic              digit_stb,
  output logic              busy,
  output logic              done
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          warm_en, conv_en, warm_last, conv_last;
  logic [TW-1:0] tick_q;
  logic          half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pps_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_req (start_req),
    .ch_trig   (ch_trig),
    .warm_last (warm_last),
    .conv_last (conv_last),
    .warm_en   (warm_en),
    .conv_en   (conv_en),
    .pwr_en_q  (pwr_en),
    .busy_q    (busy),
    .done_q    (done)
  );

  pps_timer #(
    .REC_TICKS  (REC_TICKS),
    .HALF_TICKS (HALF_TICKS),
    .N_CYCLES   (N_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .warm_en   (warm_en),
    .conv_en   (conv_en),
    .tick_q    (tick_q),
    .half_q    (half_q),
    .warm_last (warm_last),
    .conv_last (conv_last)
  );

  pps_phase #(
    .HALF_TICKS (HALF_TICKS),
    .TW         (TW),
    .DEAD_W     (DEAD_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .conv_en  (conv_en),
    .tick_q   (tick_q),
    .half_q   (half_q),
    .dead_cfg (dead_cfg),
    .ph_a_q   (ph_a),
    .ph_b_q   (ph_b),
    .stb_q    (digit_stb)
  );

  AST_PHASE_POWERED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ph_a || ph_b) |-> pwr_en); // R3
  AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> pwr_en); // R2
endmodule

// File: tb/sim_pwr_pulse_seq.sv
module sim_pwr_pulse_seq;
  localparam int CT   = 200;
  localparam int HALF = CT / 2;
  localparam int NCYC = 6;
  localparam int REC  = 200;
  localparam int DONE_J = REC + NCYC * CT + 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_req, ch_trig;
  logic [7:0] dead_cfg;
  logic       pwr_en, ph_a, ph_b, digit_stb, busy, done;

  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;

  int first_pwr, first_ph, done_j, done_cnt, pwr_after_done, pwr_any, busy_at0, busy_after_done;
  int a_cyc, b_cyc, a_rise, b_rise, stb_cnt, overlap, alt_viol, stb_viol, dark_phase, early_ph;

  always #2.5 clk = ~clk;

  pwr_pulse_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ch_trig(ch_trig),
    .dead_cfg(dead_cfg), .pwr_en(pwr_en), .ph_a(ph_a), .ph_b(ph_b),
    .digit_stb(digit_stb), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one start and records port activity; j = ticks after the sampling edge.
  task automatic measure(input logic trig, input int restart_at);
    logic pa, pb, ps;
    int last;
    first_pwr = -1; first_ph = -1; done_j = -1; done_cnt = 0; pwr_after_done = -1;
    pwr_any = 0; busy_at0 = 0; busy_after_done = -1; a_cyc = 0; b_cyc = 0;
    a_rise = 0; b_rise = 0; stb_cnt = 0; overlap = 0; alt_viol = 0; stb_viol = 0;
    dark_phase = 0; early_ph = 0;
    pa = 0; pb = 0; ps = 0; last = 1;
    ch_trig = trig;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    for (int j = 0; j < DONE_J + 6; j++) begin
      if (j == 1) busy_at0 = busy;
      if (pwr_en) begin pwr_any = 1; if (first_pwr < 0) first_pwr = j; end
      if ((ph_a || ph_b) && first_ph < 0) first_ph = j;
      if ((ph_a || ph_b) && !pwr_en) dark_phase++;
      if (ph_a && ph_b) overlap++;
      if (ph_a) a_cyc++;
      if (ph_b) b_cyc++;
      if (ph_a && !pa) begin a_rise++; if (last != 1) alt_viol++; last = 0; end
      if (ph_b && !pb) begin b_rise++; if (last != 0) alt_viol++; last = 1; end
      if (ph_a && !pa && pb) alt_viol++;
      if (ph_b && !pb && pa) alt_viol++;
      if (digit_stb) begin stb_cnt++; if (!(ph_a || ph_b)) stb_viol++; end
      if (ps && ((ph_a && pa) || (ph_b && pb))) stb_viol++;
      if (done) begin done_cnt++; if (done_j < 0) done_j = j; end
      if (done_j >= 0 && j == done_j + 1) begin pwr_after_done = pwr_en; busy_after_done = busy; end
      pa = ph_a; pb = ph_b; ps = digit_stb;
      if (j == restart_at) start_req = 1'b1;
      if (j == restart_at + 1) start_req = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_req = 1'b0; ch_trig = 1'b0; dead_cfg = 8'd3;
    repeat (4) @(negedge clk);
    chk("R1 pwr_en in reset", pwr_en, 0);
    chk("R1 phases in reset", ph_a | ph_b | digit_stb, 0);
    chk("R1 busy/done in reset", busy | done, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 outputs idle after release", pwr_en | ph_a | ph_b | digit_stb | busy | done, 0);
  endtask

  task automatic t_conv(input logic [7:0] dead, input int eff, input string tag);
    dead_cfg = dead;
    measure(1'b1, -10);
    $display("scenario %s", tag);
    chk("R2 power on tick", first_pwr, 1);
    chk("R2 busy on tick", busy_at0, 1);
    chk("R3 first phase tick", first_ph, REC + 1 + eff);
    chk("R3 phase without power", dark_phase, 0);
    chk("R4 phase A windows", a_rise, NCYC);
    chk("R4 phase B windows", b_rise, NCYC);
    chk("R4 alternation", alt_viol, 0);
    chk("R5 overlap ticks", overlap, 0);
    chk("R5 R11 phase A width total", a_cyc, NCYC * (HALF - eff));
    chk("R5 R11 phase B width total", b_cyc, NCYC * (HALF - eff));
    chk("R6 strobe count", stb_cnt, 2 * NCYC);
    chk("R6 strobe placement", stb_viol, 0);
    chk("R7 done tick", done_j, DONE_J);
    chk("R7 done pulses", done_cnt, 1);
    chk("R7 busy after done", busy_after_done, 0);
    chk("R8 power after done", pwr_after_done, 0);
  endtask

  task automatic t_untrig();
    dead_cfg = 8'd3;
    measure(1'b0, -10);
    chk("R9 done tick", done_j, 1);
    chk("R9 done pulses", done_cnt, 1);
    chk("R9 power never on", pwr_any, 0);
    chk("R9 no phases", a_rise + b_rise + stb_cnt, 0);
    chk("R9 busy low", busy_at0, 0);
  endtask

  task automatic t_restart();
    dead_cfg = 8'd4;
    measure(1'b1, 500);
    chk("R10 done tick unchanged", done_j, DONE_J);
    chk("R10 single done", done_cnt, 1);
    chk("R10 window count unchanged", a_rise + b_rise, 2 * NCYC);
    chk("R10 width unchanged", a_cyc, NCYC * (HALF - 4));
  endtask

  initial begin
    t_reset();
    t_conv(8'd3, 3, "dead 3");
    t_conv(8'd0, 1, "dead 0 clamped R11");
    t_conv(8'd255, HALF - 1, "dead 255 clamped R11");
    t_untrig();
    t_restart();
    t_conv(8'd1, 1, "dead 1 after restart");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 150000) begin
        checks++;
        errors++;
        $display("TIMEOUT: watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule